// File: doc/BRIEF.md
# Debug-Data Store Address Generator

This block executes one kind of store instruction: the stored word comes from the debug receive data register, not from a general register. When an instruction is issued, the block decodes its pre-index, up/down and writeback bits (P, U, W), its base register number and its 8-bit immediate. From the base register value it forms the effective word address. It then places one write request on a valid/ready memory port. If writeback is requested, it returns the updated base value to the register file.

Some encodings are illegal. The all-zero P/U/W combination is undefined. A base of register 15 is unpredictable in two cases: when writeback is requested, or when the instruction came from the compact instruction set. For these encodings the block pulses a flag and performs no memory access and no writeback. An instruction whose condition failed is dropped silently. While a request is outstanding the block reports busy and ignores new issues.

Top module: `dbg_store_agu`

## Requirements
- R1: The offset is imm8 multiplied by four and zero-extended to 32 bits. With U=1 the offset address is base plus offset, and with U=0 it is base minus offset. Both wrap modulo 2^32.
- R2: With P=1 the memory address is the offset address. With P=0 it is the unmodified base value, so the imm8 field has no effect on the address.
- R3: With W=1, wb_en pulses high for exactly one cycle, the cycle after the edge on which mem_valid and mem_ready are both high. During that pulse wb_idx equals Rn and wb_data equals the offset address. With W=0, wb_en stays low.
- R4: P=U=W=0 is undefined. In the cycle after acceptance undef_flag is high for one cycle, and no request or writeback follows.
- R5: Rn=15 together with either W=1 or compact_mode=1 is unpredictable. In that case unpred_flag pulses for one cycle after acceptance, and there is no request and no writeback. When the encoding is also undefined, only undef_flag is raised.
- R6: An issue with cond_pass low causes no request, no writeback and no flag.
- R7: mem_data equals the rx_data value sampled at acceptance.
- R8: mem_valid rises in the cycle after acceptance. mem_addr and mem_data hold stable until mem_ready is seen.
- R9: busy is high from the cycle after acceptance until the handshake edge. An issue while busy is ignored.
- R10: After reset, mem_valid, busy, wb_en, undef_flag and unpred_flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Instruction present this cycle |
| cond_pass | input | 1 | Instruction condition passed |
| compact_mode | input | 1 | Instruction came from the compact instruction set |
| fld_p | input | 1 | Pre-index bit |
| fld_u | input | 1 | Add (1) / subtract (0) bit |
| fld_w | input | 1 | Writeback bit |
| fld_rn | input | 4 | Base register number |
| fld_imm | input | 8 | Immediate word offset / option field |
| base_val | input | 32 | Current value of the base register |
| rx_data | input | 32 | Debug receive data register value |
| mem_ready | input | 1 | Memory accepts the request |
| mem_valid | output | 1 | Write request valid |
| mem_addr | output | 32 | Write address |
| mem_data | output | 32 | Write data |
| busy | output | 1 | Request outstanding |
| wb_en | output | 1 | Base writeback strobe |
| wb_idx | output | 4 | Base writeback register number |
| wb_data | output | 32 | Base writeback value |
| undef_flag | output | 1 | Undefined encoding pulse |
| unpred_flag | output | 1 | Unpredictable encoding pulse |

## Verification
The hardest case to reach is an issue that arrives while a request is stalled. It needs a request held pending by a low mem_ready and a second, different instruction presented during that stall. The bench drives random ready delays of up to several cycles. In directed runs it injects a colliding issue during the stall, then confirms that the address and data stay unchanged and that no second request or flag appears afterwards. Subtraction below zero and addition past 2^32 are also forced directly, using base values near both ends of the range.

// File: rtl/dbg_store_pkg.sv
package dbg_store_pkg;
    localparam int XLEN   = 32;
    localparam int REG_W  = 4;
    localparam int IMM_W  = 8;
    localparam int SCALE  = 2;
    localparam logic [REG_W-1:0] PC_IDX = REG_W'(15);

    typedef struct packed {
        logic             pre;
        logic             up;
        logic             wbk;
        logic [REG_W-1:0] rn;
        logic [IMM_W-1:0] imm;
    } instr_t;

    typedef enum logic [1:0] {
        K_SKIP   = 2'd0,
        K_EXEC   = 2'd1,
        K_UNDEF  = 2'd2,
        K_UNPRED = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e kind;
        logic  wbk;
    } dec_t;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_REQ  = 1'b1
    } seq_e;

    function automatic logic [XLEN-1:0] scale_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W-SCALE){1'b0}}, v, {SCALE{1'b0}}};
    endfunction
endpackage

// File: rtl/dsag_decode.sv
module dsag_decode
    import dbg_store_pkg::*;
(
    input  instr_t ins,
    input  logic   cond_pass,
    input  logic   compact_mode,
    output dec_t   dec
);
    logic is_undef;
    logic is_unpred;

    assign is_undef  = !(ins.pre || ins.up || ins.wbk);
    assign is_unpred = (ins.rn == PC_IDX) && (ins.wbk || compact_mode);

    always_comb begin
        dec.wbk = ins.wbk;
        if (!cond_pass)
            dec.kind = K_SKIP;
        else if (is_undef)
            dec.kind = K_UNDEF;
        else if (is_unpred)
            dec.kind = K_UNPRED;
        else
            dec.kind = K_EXEC;
    end
endmodule

// File: rtl/dsag_addr.sv
module dsag_addr
    import dbg_store_pkg::*;
(
    input  instr_t            ins,
    input  logic [XLEN-1:0]   base_val,
    output logic [XLEN-1:0]   off_addr,
    output logic [XLEN-1:0]   acc_addr
);
    logic [XLEN-1:0] offs;

    assign offs = scale_imm(ins.imm);

    always_comb begin
        if (ins.up)
            off_addr = base_val + offs;
        else
            off_addr = base_val - offs;
        acc_addr = ins.pre ? off_addr : base_val;
    end
endmodule

// File: rtl/dsag_seq.sv
module dsag_seq
    import dbg_store_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             issue,
    input  dec_t             dec,
    input  logic [REG_W-1:0] rn,
    input  logic [XLEN-1:0]  acc_addr,
    input  logic [XLEN-1:0]  off_addr,
    input  logic [XLEN-1:0]  rx_data,
    input  logic             mem_ready,
    output logic             mem_valid,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_data,
    output logic             busy,
    output logic             wb_en,
    output logic [REG_W-1:0] wb_idx,
    output logic [XLEN-1:0]  wb_data,
    output logic             undef_flag,
    output logic             unpred_flag
);
    seq_e             state;
    logic             wb_pend;
    logic [XLEN-1:0]  addr_q;
    logic [XLEN-1:0]  data_q;
    logic [XLEN-1:0]  wbv_q;
    logic [REG_W-1:0] idx_q;
    logic             wb_q;
    logic             und_q;
    logic             unp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            wb_pend <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            wbv_q   <= '0;
            idx_q   <= '0;
            wb_q    <= 1'b0;
            und_q   <= 1'b0;
            unp_q   <= 1'b0;
        end else begin
            wb_q  <= 1'b0;
            und_q <= 1'b0;
            unp_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (issue) begin
                        case (dec.kind)
                            K_EXEC: begin
                                addr_q  <= acc_addr;
                                data_q  <= rx_data;
                                wbv_q   <= off_addr;
                                idx_q   <= rn;
                                wb_pend <= dec.wbk;
                                state   <= S_REQ;
                            end
                            K_UNDEF:  und_q <= 1'b1;
                            K_UNPRED: unp_q <= 1'b1;
                            default: ;
                        endcase
                    end
                end
                S_REQ: begin
                    if (mem_ready) begin
                        wb_q  <= wb_pend;
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign mem_valid   = (state == S_REQ);
    assign busy        = (state == S_REQ);
    assign mem_addr    = addr_q;
    assign mem_data    = data_q;
    assign wb_en       = wb_q;
    assign wb_idx      = idx_q;
    assign wb_data     = wbv_q;
    assign undef_flag  = und_q;
    assign unpred_flag = unp_q;

    // R8: request held stable while stalled
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R3: writeback only right after a handshake
    p_wb_after_hs_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(wb_en) |-> $past(mem_valid && mem_ready));

    // R3: writeback strobe lasts one cycle
    p_wb_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        wb_en |=> !wb_en);

    // R4: undefined encoding produces no request
    p_undef_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (issue && !busy && dec.kind == K_UNDEF) |=> (undef_flag && !mem_valid));

    // R9: issue while busy leaves no trace
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        (issue && busy) |=> (!undef_flag && !unpred_flag));
endmodule

// File: rtl/dbg_store_agu.sv
module dbg_store_agu
    import dbg_store_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic              cond_pass,
    input  logic              compact_mode,
    input  logic              fld_p,
    input  logic              fld_u,
    input  logic              fld_w,
    input  logic [REG_W-1:0]  fld_rn,
    input  logic [IMM_W-1:0]  fld_imm,
    input  logic [XLEN-1:0]   base_val,
    input  logic [XLEN-1:0]   rx_data,
    input  logic              mem_ready,
    output logic              mem_valid,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_data,
    output logic              busy,
    output logic              wb_en,
    output logic [REG_W-1:0]  wb_idx,
    output logic [XLEN-1:0]   wb_data,
    output logic              undef_flag,
    output logic              unpred_flag
);
    instr_t          ins;
    dec_t            dec;
    logic [XLEN-1:0] off_addr;
    logic [XLEN-1:0] acc_addr;

    assign ins = '{pre: fld_p, up: fld_u, wbk: fld_w, rn: fld_rn, imm: fld_imm};

    dsag_decode u_dec (
        .ins          (ins),
        .cond_pass    (cond_pass),
        .compact_mode (compact_mode),
        .dec          (dec)
    );

    dsag_addr u_addr (
        .ins      (ins),
        .base_val (base_val),
        .off_addr (off_addr),
        .acc_addr (acc_addr)
    );

    dsag_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .issue       (issue),
        .dec         (dec),
        .rn          (fld_rn),
        .acc_addr    (acc_addr),
        .off_addr    (off_addr),
        .rx_data     (rx_data),
        .mem_ready   (mem_ready),
        .mem_valid   (mem_valid),
        .mem_addr    (mem_addr),
        .mem_data    (mem_data),
        .busy        (busy),
        .wb_en       (wb_en),
        .wb_idx      (wb_idx),
        .wb_data     (wb_data),
        .undef_flag  (undef_flag),
        .unpred_flag (unpred_flag)
    );

    // R6: failed condition has no visible effect
    p_cond_skip_r6: assert property (@(posedge clk) disable iff (rst)
        (issue && !busy && !cond_pass) |=> (!mem_valid && !undef_flag && !unpred_flag));

    // R5: unpredictable base never reaches memory
    p_unpred_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        unpred_flag |-> (!mem_valid && !undef_flag));

    // R10: quiet right after reset
    p_reset_quiet_r10: assert property (@(posedge clk)
        $past(rst) |-> (!mem_valid && !busy && !wb_en && !undef_flag && !unpred_flag));
endmodule

// File: tb/dbg_store_agu_bench.sv
module dbg_store_agu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue = 1'b0, cond_pass = 1'b0, compact_mode = 1'b0;
    logic        fld_p = 1'b0, fld_u = 1'b0, fld_w = 1'b0;
    logic [3:0]  fld_rn = '0;
    logic [7:0]  fld_imm = '0;
    logic [31:0] base_val = '0, rx_data = '0;
    logic        mem_ready = 1'b0;
    logic        mem_valid, busy, wb_en, undef_flag, unpred_flag;
    logic [31:0] mem_addr, mem_data, wb_data;
    logic [3:0]  wb_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dbg_store_agu u_dbg_store_agu (
        .clk(clk), .rst(rst), .issue(issue), .cond_pass(cond_pass),
        .compact_mode(compact_mode), .fld_p(fld_p), .fld_u(fld_u), .fld_w(fld_w),
        .fld_rn(fld_rn), .fld_imm(fld_imm), .base_val(base_val), .rx_data(rx_data),
        .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_addr(mem_addr),
        .mem_data(mem_data), .busy(busy), .wb_en(wb_en), .wb_idx(wb_idx),
        .wb_data(wb_data), .undef_flag(undef_flag), .unpred_flag(unpred_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_off(input logic u, input logic [31:0] b, input logic [7:0] i);
        logic [31:0] o;
        o = 32'(i) * 32'd4;
        return u ? b + o : b - o;
    endfunction

    function automatic logic [31:0] m_acc(input logic p, input logic u, input logic [31:0] b, input logic [7:0] i);
        return p ? m_off(u, b, i) : b;
    endfunction

    // 0 skip, 1 exec, 2 undef, 3 unpred
    function automatic int m_kind(input logic c, input logic p, input logic u, input logic w,
                                  input logic [3:0] rn, input logic cm);
        if (!c) return 0;
        if (!p && !u && !w) return 2;
        if (rn == 4'd15 && (w || cm)) return 3;
        return 1;
    endfunction

    task automatic run(input logic c, input logic cm, input logic p, input logic u, input logic w,
                       input logic [3:0] rn, input logic [7:0] imm, input logic [31:0] b,
                       input logic [31:0] rx, input int dly, input bit collide);
        int k;
        logic [31:0] ea, eo;
        k  = m_kind(c, p, u, w, rn, cm);
        ea = m_acc(p, u, b, imm);
        eo = m_off(u, b, imm);
        @(negedge clk);
        issue = 1; cond_pass = c; compact_mode = cm; fld_p = p; fld_u = u; fld_w = w;
        fld_rn = rn; fld_imm = imm; base_val = b; rx_data = rx; mem_ready = 0;
        @(negedge clk);
        issue = 0; rx_data = ~rx;
        if (k != 1) begin
            chk("R6/R4/R5 no request", 32'(mem_valid), 0);
            chk("R4 undef_flag", 32'(undef_flag), 32'(k == 2));
            chk("R5 unpred_flag", 32'(unpred_flag), 32'(k == 3));
            chk("R9 busy idle", 32'(busy), 0);
            @(negedge clk);
            chk("R4/R5 flag one cycle", 32'({undef_flag, unpred_flag}), 0);
            chk("R3 no wb", 32'(wb_en), 0);
            return;
        end
        chk("R8 mem_valid rises", 32'(mem_valid), 1);
        chk("R9 busy", 32'(busy), 1);
        chk("R1/R2 address", mem_addr, ea);
        chk("R7 data", mem_data, rx);
        for (int d = 0; d < dly; d++) begin
            if (collide && d == 0) begin
                issue = 1; cond_pass = 1; fld_p = ~p; fld_u = 1; fld_w = 0;
                fld_imm = ~imm; base_val = ~b; fld_rn = 4'd0; compact_mode = 0;
            end
            @(negedge clk);
            issue = 0;
            chk("R8 hold valid", 32'(mem_valid), 1);
            chk("R8/R9 hold addr", mem_addr, ea);
            chk("R8 hold data", mem_data, rx);
            if (collide && d == 0)
                chk("R9 ignored issue flags", 32'({undef_flag, unpred_flag}), 0);
        end
        mem_ready = 1;
        @(negedge clk);
        mem_ready = 0;
        chk("R9 busy drop", 32'(busy), 0);
        chk("R8 valid drop", 32'(mem_valid), 0);
        chk("R3 wb_en", 32'(wb_en), 32'(w));
        if (w) begin
            chk("R3 wb_idx", 32'(wb_idx), 32'(rn));
            chk("R3 wb_data", wb_data, eo);
        end
        @(negedge clk);
        chk("R3 wb one cycle", 32'(wb_en), 0);
        chk("R9 no second request", 32'(mem_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R10 mem_valid", 32'(mem_valid), 0);
        chk("R10 busy", 32'(busy), 0);
        chk("R10 flags", 32'({wb_en, undef_flag, unpred_flag}), 0);
        rst = 0;
        // directed corners
        run(1, 0, 1, 1, 0, 4'd2, 8'hFF, 32'hFFFF_FFF0, 32'hA5A5_0001, 0, 0); // R1 wrap up
        run(1, 0, 1, 0, 1, 4'd3, 8'h01, 32'h0000_0000, 32'h1234_5678, 2, 0); // R1 wrap down, R3
        run(1, 0, 0, 1, 1, 4'd4, 8'h10, 32'h0000_1000, 32'hDEAD_BEEF, 1, 0); // R2 post-index
        run(1, 0, 0, 1, 0, 4'd5, 8'hAB, 32'h0000_2000, 32'h0BAD_F00D, 0, 0); // R2 option ignored
        run(1, 0, 0, 0, 0, 4'd6, 8'h12, 32'h0000_3000, 32'h1, 0, 0);         // R4
        run(1, 1, 0, 0, 0, 4'd15, 8'h12, 32'h0000_3000, 32'h1, 0, 0);        // R4 over R5
        run(1, 0, 1, 1, 1, 4'd15, 8'h04, 32'h0000_4000, 32'h2, 0, 0);        // R5 wback
        run(1, 1, 1, 1, 0, 4'd15, 8'h04, 32'h0000_4000, 32'h3, 0, 0);        // R5 compact
        run(1, 0, 1, 1, 0, 4'd15, 8'h04, 32'h0000_4000, 32'h4, 0, 0);        // pc base allowed
        run(0, 0, 1, 1, 1, 4'd7, 8'h04, 32'h0000_5000, 32'h5, 0, 0);         // R6
        run(0, 0, 0, 0, 0, 4'd7, 8'h04, 32'h0000_5000, 32'h5, 0, 0);         // R6 undef suppressed
        run(1, 0, 1, 0, 1, 4'd8, 8'h20, 32'h0001_0000, 32'h6, 3, 1);         // R9 collision
        for (int n = 0; n < 400; n++) begin
            logic [2:0] puw;
            puw = 3'($urandom_range(0, 7));
            run(($urandom_range(0, 9) != 0), 1'($urandom_range(0, 1)), puw[2], puw[1], puw[0],
                4'($urandom_range(0, 15)), 8'($urandom), $urandom, $urandom,
                $urandom_range(0, 3), ($urandom_range(0, 7) == 0));
        end
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule